// File: doc/BRIEF.md
# Tower Energy Filter

This block turns the raw digitised pulse of one calorimeter tower into one calibrated 8-bit energy value per bunch crossing. Samples arrive at four per crossing, and a crossing strobe marks the first sample of each crossing. A programmable phase keeps two of the four samples, one in each half of the crossing. The kept samples pass through a programmable FIR filter of up to eight taps. A three-point peak detector then zeroes every filter output that is not a strict local maximum.

Only the peak result that belongs to the chosen half of the crossing goes on, so the output carries exactly one value per crossing. That value is clamped at zero, shifted right by a programmable amount and saturated to a 10-bit address. It then indexes a loadable table that yields the final energy.

Filter coefficients and table contents are written through simple write ports while the sample stream is idle. Reset clears the coefficients and the filter history but not the table.

Top module: `tower_energy_filter`

## Requirements
- R1: A sample (10-bit unsigned) is taken on every clock with `in_valid` high. The sample with `in_bx` high has phase 0, and each later valid sample has a phase one higher, modulo 4.
- R2: With `cfg_keep_odd` = 0 the samples of phase 0 and 2 are kept, and with `cfg_keep_odd` = 1 those of phase 1 and 3. The kept sample with phase below 2 is the first half of the crossing and the other is the second half.
- R3: The filter output for each kept sample is the sum over taps k of coef[k] times the kept sample k positions back, with tap 0 being the newest. Coefficients are signed 6-bit two's complement, written with `coef_we`, `coef_idx` and `coef_data`, and reset clears all coefficients and the history to zero.
- R4: The filter sum is wide enough that eight taps of +31 or −32 applied to full-scale samples never wrap.
- R5: A filter output is passed on as a peak only when it is strictly greater than both the filter output before it and the one after it. Otherwise a zero is passed on, so equal neighbours on a flat top produce zero.
- R6: Each peak result carries the half of its middle sample. Only results whose half equals `cfg_peak_half` (0 for the first half, 1 for the second) reach the output, so a steady stream gives exactly one output per crossing.
- R7: A negative peak result counts as zero. The result is then shifted right by `cfg_shift` (0 to 7) and limited to 1023 to form the table address.
- R8: The table holds 1024 entries of 8 bits, written with `lut_we`/`lut_addr`/`lut_data`. `out_energy` is the table entry at the address from R7, and `out_valid` follows the address stage by one clock.
- R9: During and right after reset, `out_valid` is 0 and `out_energy` is 0.
- R10: An isolated pulse on a zero baseline produces exactly one non-zero output, at the crossing that follows the crossing holding the peak sample, and zeros on all other crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four cycles per crossing |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this clock |
| in_bx | input | 1 | Marks the first sample of a crossing |
| in_sample | input | 10 | ADC sample, unsigned |
| cfg_keep_odd | input | 1 | Keep phases 1/3 instead of 0/2 |
| cfg_peak_half | input | 1 | Half of the crossing whose peak result is kept |
| cfg_shift | input | 3 | Right shift applied before the table |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 3 | Tap being written |
| coef_data | input | 6 | Signed coefficient value |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 10 | Table write address |
| lut_data | input | 8 | Table write data |
| out_valid | output | 1 | Calibrated energy present |
| out_energy | output | 8 | Calibrated transverse energy |

## Verification
The hardest situation to reach is a peak that is correctly found but dropped because it sits in the unselected half of the crossing, together with flat tops where equal neighbours must cancel a peak. The stimulus uses one fixed pulse shape. It is replayed with both sampling phases and both half selections, so the same peak is kept in one run and discarded in another. A flat-topped pulse and strongly negative coefficients drive the equality and clamp paths. Full-scale coefficients on a large pseudo-random stream force address saturation.

// File: rtl/tef_pkg.sv
package tef_pkg;

    localparam int SMP_W    = 10;
    localparam int COEF_W   = 6;
    localparam int TAPS_MAX = 8;
    localparam int E_W      = 8;
    localparam int LUT_AW   = 10;
    localparam int SHIFT_W  = 3;
    localparam int ACC_W    = SMP_W + COEF_W + $clog2(TAPS_MAX) + 1;
    localparam int LUT_MAX  = (1 << LUT_AW) - 1;

    typedef logic        [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic        [LUT_AW-1:0] lut_addr_t;

    typedef struct packed {
        logic valid;
        logic half;
        smp_t data;
    } kept_t;

    typedef struct packed {
        logic valid;
        logic half;
        acc_t val;
    } flt_t;

    // Clamp negative to zero, shift, saturate to table range.
    function automatic lut_addr_t scale_addr(acc_t v, logic [SHIFT_W-1:0] sh);
        acc_t s;
        if (v < 0) begin
            return '0;
        end
        s = v >>> sh;
        if (s > acc_t'(LUT_MAX)) begin
            return '1;
        end
        return s[LUT_AW-1:0];
    endfunction

endpackage

// File: rtl/tef_decim.sv
module tef_decim
    import tef_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_bx,
    input  smp_t  in_sample,
    input  logic  keep_odd,
    output kept_t kept_o
);

    logic [1:0] ph_q;
    logic [1:0] ph_cur;
    logic       take;

    always_comb begin
        ph_cur = in_bx ? 2'd0 : ph_q;
        take   = in_valid && (ph_cur[0] == keep_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 2'd0;
            kept_o <= '0;
        end else begin
            if (in_valid) begin
                ph_q <= ph_cur + 2'd1;
            end
            kept_o.valid <= take;
            kept_o.half  <= ph_cur[1];
            kept_o.data  <= in_sample;
        end
    end

    // Checker state: half of the previously kept sample.
    logic last_half;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_half <= 1'b1;
        end else if (kept_o.valid) begin
            last_half <= kept_o.half;
        end
    end

    // R2: kept samples alternate between the two halves of a crossing
    a_r2_half_alternates: assert property (@(posedge clk) disable iff (rst)
        kept_o.valid |-> (kept_o.half != last_half));

endmodule

// File: rtl/tef_fir.sv
module tef_fir
    import tef_pkg::*;
#(
    parameter int TAPS = TAPS_MAX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     coef_we,
    input  logic [$clog2(TAPS)-1:0]  coef_idx,
    input  coef_t                    coef_data,
    input  kept_t                    kept_i,
    output flt_t                     fir_o
);

    localparam int IDX_W = $clog2(TAPS);

    coef_t coef_q [TAPS];
    smp_t  hist_q [TAPS-1];
    smp_t  tap_c  [TAPS];
    acc_t  sum_c;

    for (genvar k = 0; k < TAPS; k++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst) begin
                coef_q[k] <= '0;
            end else if (coef_we && coef_idx == IDX_W'(k)) begin
                coef_q[k] <= coef_data;
            end
        end
    end

    for (genvar k = 0; k < TAPS - 1; k++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[k] <= '0;
            end else if (kept_i.valid) begin
                hist_q[k] <= tap_c[k];
            end
        end
    end

    always_comb begin
        tap_c[0] = kept_i.data;
        for (int k = 1; k < TAPS; k++) begin
            tap_c[k] = hist_q[k-1];
        end
    end

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_c = sum_c + acc_t'(coef_q[k]) * acc_t'($signed({1'b0, tap_c[k]}));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fir_o <= '0;
        end else begin
            fir_o.valid <= kept_i.valid;
            fir_o.half  <= kept_i.half;
            if (kept_i.valid) begin
                fir_o.val <= sum_c;
            end
        end
    end

endmodule

// File: rtl/tef_peak.sv
module tef_peak
    import tef_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  flt_t fir_i,
    output flt_t peak_o
);

    acc_t y1_q;
    acc_t y2_q;
    logic is_peak;

    always_comb begin
        is_peak = (y1_q > y2_q) && (y1_q > fir_i.val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y1_q   <= '0;
            y2_q   <= '0;
            peak_o <= '0;
        end else begin
            peak_o.valid <= fir_i.valid;
            if (fir_i.valid) begin
                peak_o.val  <= is_peak ? y1_q : '0;
                peak_o.half <= ~fir_i.half;
                y2_q        <= y1_q;
                y1_q        <= fir_i.val;
            end
        end
    end

    // R5: a non-zero peak is strictly above the sample that followed it
    a_r5_strict_peak: assert property (@(posedge clk) disable iff (rst)
        (peak_o.valid && peak_o.val != '0) |-> (peak_o.val > $past(fir_i.val)));

endmodule

// File: rtl/tower_energy_filter.sv
module tower_energy_filter
    import tef_pkg::*;
#(
    parameter int TAPS = TAPS_MAX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_bx,
    input  logic [SMP_W-1:0]        in_sample,
    input  logic                    cfg_keep_odd,
    input  logic                    cfg_peak_half,
    input  logic [SHIFT_W-1:0]      cfg_shift,
    input  logic                    coef_we,
    input  logic [$clog2(TAPS)-1:0] coef_idx,
    input  logic [COEF_W-1:0]       coef_data,
    input  logic                    lut_we,
    input  logic [LUT_AW-1:0]       lut_addr,
    input  logic [E_W-1:0]          lut_data,
    output logic                    out_valid,
    output logic [E_W-1:0]          out_energy
);

    localparam int LUT_DEPTH = 1 << LUT_AW;

    kept_t     kept;
    flt_t      fir;
    flt_t      pk;
    logic      sc_valid;
    lut_addr_t sc_addr;
    logic [E_W-1:0] lut_mem [LUT_DEPTH];

    tef_decim u_decim (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bx     (in_bx),
        .in_sample (in_sample),
        .keep_odd  (cfg_keep_odd),
        .kept_o    (kept)
    );

    tef_fir #(.TAPS(TAPS)) u_fir (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_data (coef_t'(coef_data)),
        .kept_i    (kept),
        .fir_o     (fir)
    );

    tef_peak u_peak (
        .clk    (clk),
        .rst    (rst),
        .fir_i  (fir),
        .peak_o (pk)
    );

    // Half selection and scaling to a table address.
    always_ff @(posedge clk) begin
        if (rst) begin
            sc_valid <= 1'b0;
            sc_addr  <= '0;
        end else begin
            sc_valid <= pk.valid && (pk.half == cfg_peak_half);
            sc_addr  <= scale_addr(pk.val, cfg_shift);
        end
    end

    always_ff @(posedge clk) begin
        if (lut_we) begin
            lut_mem[lut_addr] <= lut_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_energy <= '0;
        end else begin
            out_valid <= sc_valid;
            if (sc_valid) begin
                out_energy <= lut_mem[sc_addr];
            end
        end
    end

    // R7: a non-zero address only comes from a positive peak result
    a_r7_clamp_negative: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && sc_addr != '0) |-> ($past(pk.val) > 0));

    // R8: table output follows the address stage by one clock
    a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(sc_valid));

    // R6: never two results on adjacent clocks
    a_r6_one_per_crossing: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: tb/tower_energy_filter_bench.sv
module tower_energy_filter_bench;
    import tef_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_bx = 1'b0;
    logic [9:0]  in_sample = '0;
    logic        cfg_keep_odd = 1'b0, cfg_peak_half = 1'b0;
    logic [2:0]  cfg_shift = '0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_idx = '0;
    logic [5:0]  coef_data = '0;
    logic        lut_we = 1'b0;
    logic [9:0]  lut_addr = '0;
    logic [7:0]  lut_data = '0;
    logic        out_valid;
    logic [7:0]  out_energy;

    tower_energy_filter u_tower_energy_filter (.*);

    int n_checks = 0, n_fail = 0;
    int lut_ref [1024];
    int coef_ref [8];
    int hist [8];
    int y1, y2, ph;
    int exp_q [$];
    int n_out, nz_cnt, nz_idx;

    function automatic int lutf(int a);
        return (a == 0) ? 0 : ((a * 7) % 255) + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of one input sample (R1..R8).
    task automatic model_sample(int s, bit bx);
        int p, y, pk, a;
        bit half, tag;
        p    = bx ? 0 : ph;
        half = (p >= 2);
        ph   = (p + 1) % 4;
        if ((p % 2) == int'(cfg_keep_odd)) begin
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = s;
            y = 0;
            for (int k = 0; k < 8; k++) y += coef_ref[k] * hist[k];
            pk  = (y1 > y2 && y1 > y) ? y1 : 0;
            tag = !half;
            y2  = y1;
            y1  = y;
            if (tag == cfg_peak_half) begin
                a = (pk < 0) ? 0 : (pk >>> cfg_shift);
                if (a > 1023) a = 1023;
                exp_q.push_back(lut_ref[a]);
            end
        end
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected output", int'(out_energy), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(out_energy) == e, "R8 energy", int'(out_energy), e);
            end
            if (out_energy != 0) begin
                nz_cnt++;
                nz_idx = n_out;
            end
            n_out++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin hist[k] = 0; coef_ref[k] = 0; end
        y1 = 0; y2 = 0; ph = 0;
        exp_q.delete();
        n_out = 0; nz_cnt = 0; nz_idx = -1;
    endtask

    task automatic load_coefs(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
        int c [8];
        c = '{c0, c1, c2, c3, c4, c5, c6, c7};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_idx = 3'(k); coef_data = 6'(c[k]);
            coef_ref[k] = c[k];
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    function automatic int sample_at(int mode, int i);
        if (mode == 1) return (i * 37 + i * i * 11 + 5) % 1024;
        if (i < 40 || i > 47) return 0;
        if (mode == 2) return 200;
        case (i - 40)
            0: return 50;   1: return 300; 2: return 600; 3: return 400;
            4: return 250;  5: return 100; 6: return 40;  default: return 10;
        endcase
    endfunction

    localparam int NX = 24;

    task automatic run(int mode, string req);
        for (int i = 0; i < NX * 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_bx = (i % 4 == 0); in_sample = 10'(sample_at(mode, i));
            model_sample(sample_at(mode, i), i % 4 == 0);
        end
        @(negedge clk);
        in_valid = 1'b0; in_bx = 1'b0;
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, {req, " missing outputs"}, exp_q.size(), 0);
        check(n_out == NX, "R6 one output per crossing", n_out, NX);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int a = 0; a < 1024; a++) begin
            @(negedge clk);
            lut_we = 1'b1; lut_addr = 10'(a); lut_data = 8'(lutf(a));
            lut_ref[a] = lutf(a);
        end
        @(negedge clk);
        lut_we = 1'b0;

        // R9: reset state
        do_reset();
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        check(out_energy == 8'd0, "R9 out_energy after reset", int'(out_energy), 0);

        // R10/R1: isolated pulse, phases 0/2, second-half peak kept
        cfg_keep_odd = 1'b0; cfg_peak_half = 1'b1; cfg_shift = 3'd0;
        load_coefs(1, 0, 0, 0, 0, 0, 0, 0);
        run(0, "R10");
        check(nz_cnt == 1, "R10 single non-zero output", nz_cnt, 1);
        check(nz_idx == 11, "R1/R10 crossing of non-zero output", nz_idx, 11);

        // R6: same pulse, first-half selection drops the peak
        do_reset();
        cfg_peak_half = 1'b0;
        load_coefs(1, 0, 0, 0, 0, 0, 0, 0);
        run(0, "R6");
        check(nz_cnt == 0, "R6 unselected half dropped", nz_cnt, 0);

        // R2: odd phases keep 300,400,100,10
        do_reset();
        cfg_keep_odd = 1'b1; cfg_peak_half = 1'b1;
        load_coefs(1, 0, 0, 0, 0, 0, 0, 0);
        run(0, "R2");
        check(nz_cnt == 1, "R2 odd-phase pulse count", nz_cnt, 1);

        // R3: mixed-sign eight-tap filter on pseudo-random data
        do_reset();
        cfg_keep_odd = 1'b1; cfg_peak_half = 1'b1; cfg_shift = 3'd2;
        load_coefs(3, -2, 5, 1, -7, 4, 2, -1);
        run(1, "R3");

        // R4/R7: full-scale positive taps, saturation
        do_reset();
        cfg_keep_odd = 1'b0; cfg_peak_half = 1'b0; cfg_shift = 3'd0;
        load_coefs(31, 31, 31, 31, 31, 31, 31, 31);
        run(1, "R4");

        // R7: all-negative taps clamp to zero
        do_reset();
        cfg_shift = 3'd1;
        load_coefs(-32, -32, -32, -32, -32, -32, -32, -32);
        run(1, "R7");
        check(nz_cnt == 0, "R7 negative clamped", nz_cnt, 0);

        // R5: flat top yields no peak
        do_reset();
        cfg_peak_half = 1'b1; cfg_shift = 3'd0;
        load_coefs(1, 0, 0, 0, 0, 0, 0, 0);
        run(2, "R5");
        check(nz_cnt == 0, "R5 flat top not a peak", nz_cnt, 0);

        // R7: largest shift
        do_reset();
        cfg_shift = 3'd7;
        load_coefs(1, 1, 0, 0, 0, 0, 0, 0);
        run(1, "R7 shift");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule